// File: doc/BRIEF.md
# Serial Port-Receive Status Exporter

This block watches a set of per-port receive strobes and records, for each fixed observation window, which ports saw at least one packet. When a window closes, the recorded word is captured and a fresh, empty window starts at once. During that new window the captured word is sent out over three wires: a serial data line, a shift clock for external shift registers and a load strobe that tells external latches to take the shifted word. Collection and output therefore overlap, and each window's word appears on the wires one window later.

All timing is counted in cycles of the bit clock and is a power of two. A window lasts 2^WIN_LOG cycles (default 2^17). Each serial bit occupies a slot of 2^BIT_LOG cycles (default 2^12). The data changes at the start of the slot, and the shift clock rises 2^SETUP_LOG cycles later (default 2^11). With eight ports, the data phase lasts 2^15 cycles. One more slot carries the load pulse. The line then stays idle until the next window ends. The block is built from a window timer, a per-port accumulator and a shift/load state machine.

State machine: ST_WAIT (after reset, no word yet) goes to ST_SHIFT when the window ends. ST_SHIFT goes to ST_LATCH at the end of the slot for the last bit. ST_LATCH goes to ST_IDLE at the end of its slot. ST_IDLE goes to ST_SHIFT when the window ends. For these transitions to work, NPORTS+1 slots must fit inside one window.

Top module: `rxstat_serializer`

## Requirements
- R1: A strobe on port_rx[p] in any cycle of a window sets bit p of that window's status word. Repeated strobes on the same port leave the bit at 1. Ports with no strobe give 0.
- R2: A strobe in the last cycle of a window counts toward that window. A strobe in the first cycle of the next window counts only toward the next window, because the accumulator starts each window cleared.
- R3: The word for window n is shifted out during window n+1, starting in its first cycle. Successive shift-clock rising edges are 2^BIT_LOG cycles apart.
- R4: In each bit slot, ser_clk is low for the first 2^SETUP_LOG cycles and high for the remaining 2^BIT_LOG-2^SETUP_LOG cycles. ser_data is stable while ser_clk is high.
- R5: Exactly NPORTS bits are shifted per word. The highest-numbered port goes first and port 0 goes last, so a shift register clocked on the rising edge of ser_clk holds bit p at position p.
- R6: In the slot directly after the last data bit, ser_load is high for exactly 2^BIT_LOG cycles. ser_data and ser_clk are low whenever ser_load is high.
- R7: Once running, ser_load rises exactly once every 2^WIN_LOG cycles.
- R8: During reset and throughout the first window after reset, all three outputs are low. The first load pulse rises 2^WIN_LOG + NPORTS*2^BIT_LOG cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| port_rx | input | NPORTS | One receive strobe per port, high for a cycle when a packet arrives |
| ser_data | output | 1 | Serial status data, highest port first |
| ser_clk | output | 1 | Shift clock; rising edge is mid-slot |
| ser_load | output | 1 | Latch strobe, one slot wide after the last bit |

## Verification
The assertions check on every cycle that ser_data holds steady while ser_clk is high, that ser_load never overlaps the shift clock or a high data bit, and that the accumulator is empty right after each window boundary. Only the bench scenarios can show the following: that the correct word reaches the wires one window late and in descending port order, that strobes on either side of a window boundary land in the correct word, and that slot, setup, load and window spacing match their exact cycle counts.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2,
        ST_IDLE  = 2'd3
    } exp_state_e;
endpackage

// File: rtl/rxstat_window_timer.sv
module rxstat_window_timer #(
    parameter int WIN_LOG = 17,
    parameter int BIT_LOG = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               win_end,
    output logic               slot_end,
    output logic [BIT_LOG-1:0] phase
);
    localparam logic [WIN_LOG-1:0] WIN_LAST  = '1;
    localparam logic [BIT_LOG-1:0] SLOT_LAST = '1;

    logic [WIN_LOG-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) wcnt <= '0;
        else        wcnt <= wcnt + 1'b1;
    end

    assign win_end  = (wcnt == WIN_LAST);
    assign phase    = wcnt[BIT_LOG-1:0];
    assign slot_end = (phase == SLOT_LAST);
endmodule

// File: rtl/rxstat_accum.sv
module rxstat_accum #(
    parameter int NPORTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] port_rx,
    input  logic              win_end,
    output logic [NPORTS-1:0] acc,
    output logic [NPORTS-1:0] snap
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (!rst_n || win_end) acc[p] <= 1'b0;
            else if (port_rx[p])   acc[p] <= 1'b1;
        end
        assign snap[p] = acc[p] | port_rx[p];
    end
endmodule

// File: rtl/rxstat_shift_fsm.sv
module rxstat_shift_fsm
    import rxstat_pkg::*;
#(
    parameter int NPORTS    = 8,
    parameter int BIT_LOG   = 12,
    parameter int SETUP_LOG = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_end,
    input  logic               slot_end,
    input  logic [BIT_LOG-1:0] phase,
    input  logic [NPORTS-1:0]  snap,
    output logic               ser_data,
    output logic               ser_clk,
    output logic               ser_load
);
    localparam int IDXW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam logic [IDXW-1:0]    LAST_BIT  = IDXW'(NPORTS - 1);
    localparam logic [BIT_LOG-1:0] SETUP_CNT = BIT_LOG'(1 << SETUP_LOG);

    exp_state_e        state, state_nx;
    logic [IDXW-1:0]   bit_idx;
    logic [NPORTS-1:0] sreg;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:  if (win_end) state_nx = ST_SHIFT;
            ST_SHIFT: if (slot_end && bit_idx == LAST_BIT) state_nx = ST_LATCH;
            ST_LATCH: if (slot_end) state_nx = ST_IDLE;
            ST_IDLE:  if (win_end) state_nx = ST_SHIFT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_WAIT;
            bit_idx <= '0;
            sreg    <= '0;
        end else begin
            state <= state_nx;
            if (win_end) begin
                sreg    <= snap;
                bit_idx <= '0;
            end else if (state == ST_SHIFT && slot_end) begin
                sreg    <= {sreg[NPORTS-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        ser_data = 1'b0;
        ser_clk  = 1'b0;
        ser_load = 1'b0;
        unique case (state)
            ST_SHIFT: begin
                ser_data = sreg[NPORTS-1];
                ser_clk  = (phase >= SETUP_CNT);
            end
            ST_LATCH: ser_load = 1'b1;
            ST_WAIT, ST_IDLE: ;
        endcase
    end
endmodule

// File: rtl/rxstat_serializer.sv
module rxstat_serializer #(
    parameter int NPORTS    = 8,
    parameter int WIN_LOG   = 17,
    parameter int BIT_LOG   = 12,
    parameter int SETUP_LOG = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] port_rx,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_load
);
    logic               win_end;
    logic               slot_end;
    logic [BIT_LOG-1:0] phase;
    logic [NPORTS-1:0]  acc;
    logic [NPORTS-1:0]  snap;

    rxstat_window_timer #(.WIN_LOG(WIN_LOG), .BIT_LOG(BIT_LOG)) timer_i (
        .clk(clk), .rst_n(rst_n), .win_end(win_end),
        .slot_end(slot_end), .phase(phase)
    );

    rxstat_accum #(.NPORTS(NPORTS)) accum_i (
        .clk(clk), .rst_n(rst_n), .port_rx(port_rx),
        .win_end(win_end), .acc(acc), .snap(snap)
    );

    rxstat_shift_fsm #(.NPORTS(NPORTS), .BIT_LOG(BIT_LOG), .SETUP_LOG(SETUP_LOG)) fsm_i (
        .clk(clk), .rst_n(rst_n), .win_end(win_end), .slot_end(slot_end),
        .phase(phase), .snap(snap), .ser_data(ser_data),
        .ser_clk(ser_clk), .ser_load(ser_load)
    );
endmodule

// File: rtl/rxstat_serializer_chk.sv
module rxstat_serializer_chk #(
    parameter int NPORTS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_data,
    input logic              ser_clk,
    input logic              ser_load,
    input logic              win_end,
    input logic [NPORTS-1:0] acc
);
    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R4
    data_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));

    // R6
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |-> (!ser_clk && !ser_data));

    // R2
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (acc == '0));
endmodule

bind rxstat_serializer rxstat_serializer_chk #(.NPORTS(NPORTS)) chk_i (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_load(ser_load), .win_end(win_end), .acc(acc)
);

// File: tb/rxstat_serializer_tb_top.sv
`timescale 1ns/1ps
module rxstat_serializer_tb_top;
    localparam int NP   = 8;
    localparam int WL   = 8;
    localparam int BL   = 4;
    localparam int SL   = 3;
    localparam int WIN  = 1 << WL;
    localparam int SLOT = 1 << BL;
    localparam int SET  = 1 << SL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] port_rx = '0;
    logic          ser_data, ser_clk, ser_load;

    int n_checks = 0;
    int n_fail   = 0;
    int edges    = 0;
    logic [NP-1:0] exp_q[$];

    always #10 clk = ~clk;

    rxstat_serializer #(.NPORTS(NP), .WIN_LOG(WL), .BIT_LOG(BL), .SETUP_LOG(SL)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_rx(port_rx),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load)
    );

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic pulse(input int e, input logic [NP-1:0] m);
        while (edges != e) @(negedge clk);
        port_rx = m;
        @(negedge clk);
        port_rx = '0;
    endtask

    // monitor
    logic          p_clk = 0, p_load = 0, p_data = 0, rise_data = 0;
    int            bits = 0, hi_cnt = 0, ld_cnt = 0, last_rise = 0, last_load = -1;
    logic [NP-1:0] word = '0;
    logic [NP-1:0] expw;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk && !p_clk) begin
                if (bits > 0) check(edges - last_rise == SLOT, "R3 bit spacing", edges - last_rise, SLOT);
                word = {word[NP-2:0], ser_data};
                bits++;
                last_rise = edges;
                rise_data = ser_data;
            end
            if (ser_clk) hi_cnt++;
            if (!ser_clk && p_clk) begin
                check(hi_cnt == SLOT - SET, "R4 clock high width", hi_cnt, SLOT - SET);
                check(p_data == rise_data, "R4 data held", p_data, rise_data);
                hi_cnt = 0;
            end
            if (ser_load && !p_load) begin
                check(bits == NP, "R5 bit count", bits, NP);
                check(!ser_clk && !ser_data, "R6 quiet during load", {ser_clk, ser_data}, 0);
                if (last_load < 0)
                    check(edges == WIN + NP * SLOT, "R8 first load time", edges, WIN + NP * SLOT);
                else
                    check(edges - last_load == WIN, "R7 load spacing", edges - last_load, WIN);
                last_load = edges;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected word", word, 0);
                end else begin
                    expw = exp_q.pop_front();
                    check(word == expw, "R1/R2/R5 status word", word, expw);
                end
                bits = 0;
                word = '0;
            end
            if (ser_load) ld_cnt++;
            if (!ser_load && p_load) begin
                check(ld_cnt == SLOT, "R6 load width", ld_cnt, SLOT);
                ld_cnt = 0;
            end
            p_clk  = ser_clk;
            p_load = ser_load;
            p_data = ser_data;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check({ser_data, ser_clk, ser_load} == 3'b000, "R8 outputs in reset", {ser_data, ser_clk, ser_load}, 0);
        rst_n = 1'b1;
        fork
            begin
                // R1: two ports, one repeated
                pulse(5, 8'h09);
                pulse(100, 8'h01);
                exp_q.push_back(8'h09);
                // R8: nothing on the wires during the first window
                check({ser_data, ser_clk, ser_load} == 3'b000, "R8 idle first window", {ser_data, ser_clk, ser_load}, 0);
                // R1/R5: all ports, spread
                pulse(WIN + 3, 8'h0F);
                pulse(WIN + 200, 8'hF0);
                pulse(WIN + 201, 8'h80);
                exp_q.push_back(8'hFF);
                // R1: empty window
                exp_q.push_back(8'h00);
                // R2: last cycle of window 3 belongs to window 3
                pulse(4 * WIN - 1, 8'h80);
                exp_q.push_back(8'h80);
                // R2: first cycle of window 4 belongs to window 4
                pulse(4 * WIN, 8'h01);
                pulse(4 * WIN + 50, 8'h24);
                exp_q.push_back(8'h25);
                pulse(5 * WIN + 10, 8'h42);
                exp_q.push_back(8'h42);
                while (edges < 7 * WIN + 20) @(negedge clk);
                check(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 0);
            end
            begin
                repeat (100000) @(negedge clk);
                check(1'b0, "watchdog", edges, 0);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule